// File: doc/BRIEF.md
# Channel Controller Command Queue and Condition Registers

This block is the host-facing control core of a data channel controller. The host issues transfer commands by writing transfer-control words. The controller holds up to two of them, one in a primary slot that the channel sequencer is running and one in a secondary slot that waits behind it. A control write sets the interrupt level and the enables, clears flags with write-one bits, deletes the waiting command, stops the running one, rewinds the command list or resets the controller. A status word reports occupancy, completion, attention and errors.

A transfer-control word is `CMD_W` bits wide and is handed to the sequencer unchanged. It carries a negative block count in bits 15..6 and flags for storing status after the transfer, continuing past errors and resetting the channel on start. The sequencer signals that the running command has finished with `xfer_done_i`. Error events and drive attention arrive on plain input pins. An interrupt request is raised at the programmed level whenever completion, or enabled attention, is pending.

Top module: `chan_ctl`

## Requirements
- R1: The status word `coni_o` holds the interrupt level in bits 2..0, done in bit 3, primary-full in bit 4, attention-enable in bit 5, secondary-full in bit 6, attention in bit 7, bus enable in bit 8, overrun in bit 9, register access error in bit 11, drive response error in bit 12, short word count in bit 14, long word count in bit 15, exception in bit 16 and data-bus parity in bit 17. All other bits read 0, and the whole word is 0 after reset.
- R2: A control write with bit 10 clear loads the interrupt level from bits 2..0, attention-enable from bit 5 and bus enable from bit 8. Writing 0 to bit 5 or bit 8 clears the enable.
- R3: A transfer-control write while the primary slot is empty fills the primary slot. In the next cycle `start_o` is high for exactly one cycle and `start_cmd_o` equals the written word.
- R4: A transfer-control write while only the primary slot is full fills the secondary slot and does not pulse `start_o`.
- R5: A transfer-control write while both slots are full is dropped, leaves both slots unchanged and sets the register access error.
- R6: `xfer_done_i` while the primary slot is full sets done. If the secondary slot is full, its command moves to the primary slot and is started one cycle later, and secondary-full clears. If the secondary slot is empty, primary-full clears. `xfer_done_i` with the primary slot empty has no effect.
- R7: Within one cycle the controller first applies the completion, then the delete, then places the new write into the first slot that is empty in the resulting state.
- R8: Control-write bit 6 empties the secondary slot. Bit 4 gives a one-cycle `stop_o` pulse in the next cycle. Bit 7 gives a one-cycle `list_rst_o` pulse in the next cycle.
- R9: `err_i[0..5]` set overrun, drive response, short word count, long word count, exception and data-bus parity. Control-write bit 9 clears those six flags but not the register access error. Bit 11 clears the register access error. A flag that is set in the same cycle as it is cleared ends up set.
- R10: Control-write bit 3 clears done. A completion in the same cycle wins and leaves done set.
- R11: `irq_o` is high exactly when the level is nonzero and either done is set, or attention and attention-enable are both set. `irq_lvl_o` equals the level.
- R12: A control write with bit 10 set empties both slots and clears done, all error flags, both enables and the level. It ignores every other bit of that write, and also any transfer-control write or completion in the same cycle.
- R13: Status bit 7 shows `attn_i` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cono_we_i | input | 1 | Control write strobe |
| cono_data_i | input | 12 | Control write data |
| stcr_we_i | input | 1 | Transfer-control write strobe |
| stcr_data_i | input | CMD_W | Transfer-control word |
| xfer_done_i | input | 1 | Running command completed |
| err_i | input | 6 | Error event pulses |
| attn_i | input | 1 | Drive attention |
| coni_o | output | 18 | Status word |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Interrupt level |
| start_o | output | 1 | Start pulse to the sequencer |
| start_cmd_o | output | CMD_W | Command being started |
| stop_o | output | 1 | Stop pulse to the sequencer |
| list_rst_o | output | 1 | Command-list pointer reset pulse |

## Verification
The bench builds the block at its default `CMD_W` of 36. The level field, the six error inputs and the two-slot queue are fixed in size, so the full state space is small. This makes exhaustive sweeps practical. All eight combinations of write, completion and delete are applied in the same cycle from each of the empty, one-full and two-full queue states. All eight levels are crossed with done, attention and attention-enable. Every error flag is set and cleared on its own, and also set and cleared in the same cycle.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int LVL_W  = 3;
  localparam int ERR_N  = 6;
  localparam int CONO_W = 12;
  localparam int CONI_W = 18;

  // control write bit positions
  localparam int C_CLR_DONE = 3;
  localparam int C_STOP     = 4;
  localparam int C_ATE      = 5;
  localparam int C_DEL_SEC  = 6;
  localparam int C_LIST_RST = 7;
  localparam int C_BUS_EN   = 8;
  localparam int C_CLR_XFER = 9;
  localparam int C_RESET    = 10;
  localparam int C_CLR_RAE  = 11;

  // status word bit positions
  localparam int S_DONE  = 3;
  localparam int S_PFULL = 4;
  localparam int S_ATE   = 5;
  localparam int S_SFULL = 6;
  localparam int S_ATTN  = 7;
  localparam int S_BUSEN = 8;
  localparam int S_RAE   = 11;

  function automatic int err_pos(input int i);
    case (i)
      0:       return 9;
      1:       return 12;
      2:       return 14;
      3:       return 15;
      4:       return 16;
      default: return 17;
    endcase
  endfunction
endpackage

// File: rtl/chan_cmd_queue.sv
module chan_cmd_queue #(
  parameter int CMD_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic             cmpl_i,
  input  logic             del_i,
  output logic             prim_full_o,
  output logic             sec_full_o,
  output logic             drop_o,
  output logic             start_o,
  output logic [CMD_W-1:0] start_cmd_o
);
  logic             prim_q, sec_q, start_q;
  logic [CMD_W-1:0] prim_cmd_q, sec_cmd_q;
  logic             prim_d, sec_d, start_d, drop_d;
  logic [CMD_W-1:0] prim_cmd_d, sec_cmd_d;

  // order: completion, delete, then placement of the new write
  always_comb begin
    prim_d     = prim_q;
    sec_d      = sec_q;
    prim_cmd_d = prim_cmd_q;
    sec_cmd_d  = sec_cmd_q;
    start_d    = 1'b0;
    drop_d     = 1'b0;
    if (clr_i) begin
      prim_d = 1'b0;
      sec_d  = 1'b0;
    end else begin
      if (cmpl_i && prim_q) begin
        if (sec_q) begin
          prim_cmd_d = sec_cmd_q;
          sec_d      = 1'b0;
          start_d    = 1'b1;
        end else begin
          prim_d = 1'b0;
        end
      end
      if (del_i) sec_d = 1'b0;
      if (wr_i) begin
        if (!prim_d) begin
          prim_cmd_d = wr_data_i;
          prim_d     = 1'b1;
          start_d    = 1'b1;
        end else if (!sec_d) begin
          sec_cmd_d = wr_data_i;
          sec_d     = 1'b1;
        end else begin
          drop_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prim_q     <= 1'b0;
      sec_q      <= 1'b0;
      start_q    <= 1'b0;
      prim_cmd_q <= '0;
      sec_cmd_q  <= '0;
    end else begin
      prim_q     <= prim_d;
      sec_q      <= sec_d;
      start_q    <= start_d;
      prim_cmd_q <= prim_cmd_d;
      sec_cmd_q  <= sec_cmd_d;
    end
  end

  assign prim_full_o = prim_q;
  assign sec_full_o  = sec_q;
  assign drop_o      = drop_d;
  assign start_o     = start_q;
  assign start_cmd_o = prim_cmd_q;

  p_sec_behind_prim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> prim_q);
  p_start_has_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> prim_q);
  p_promote_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && prim_q && sec_q && !clr_i) |=> (start_q && prim_q));
  p_write_empty_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !prim_q && !clr_i) |=> (start_q && prim_q));
endmodule

// File: rtl/chan_flags.sv
module chan_flags
  import chan_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             ate_i,
  input  logic             ben_i,
  input  logic             clr_done_i,
  input  logic             clr_xfer_i,
  input  logic             clr_rae_i,
  input  logic             done_set_i,
  input  logic [ERR_N-1:0] err_i,
  input  logic             rae_set_i,
  input  logic             attn_i,
  output logic             done_o,
  output logic             ate_o,
  output logic             ben_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             attn_o,
  output logic [ERR_N-1:0] err_o,
  output logic             rae_o,
  output logic             irq_o
);
  logic             done_q, ate_q, ben_q, attn_q, rae_q;
  logic [LVL_W-1:0] lvl_q;
  logic [ERR_N-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ate_q  <= 1'b0;
      ben_q  <= 1'b0;
      lvl_q  <= '0;
      rae_q  <= 1'b0;
    end else if (clr_i) begin
      done_q <= 1'b0;
      ate_q  <= 1'b0;
      ben_q  <= 1'b0;
      lvl_q  <= '0;
      rae_q  <= 1'b0;
    end else begin
      if (done_set_i)      done_q <= 1'b1;
      else if (clr_done_i) done_q <= 1'b0;
      if (rae_set_i)       rae_q  <= 1'b1;
      else if (clr_rae_i)  rae_q  <= 1'b0;
      if (ld_i) begin
        lvl_q <= lvl_i;
        ate_q <= ate_i;
        ben_q <= ben_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) attn_q <= 1'b0;
    else         attn_q <= attn_i;
  end

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         err_q[g] <= 1'b0;
      else if (clr_i)      err_q[g] <= 1'b0;
      else if (err_i[g])   err_q[g] <= 1'b1;
      else if (clr_xfer_i) err_q[g] <= 1'b0;
    end
  end

  assign irq_o  = (lvl_q != '0) && (done_q || (attn_q && ate_q));
  assign done_o = done_q;
  assign ate_o  = ate_q;
  assign ben_o  = ben_q;
  assign lvl_o  = lvl_q;
  assign attn_o = attn_q;
  assign err_o  = err_q;
  assign rae_o  = rae_q;

  p_clr_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_done_i && !done_set_i) |=> !done_q);
  p_rae_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_xfer_i && !clr_rae_i && !clr_i) |=> (rae_q || !$past(rae_q)));
  p_reset_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_q && !ate_q && !ben_q && lvl_q == '0 && err_q == '0 && !rae_q));
endmodule

// File: rtl/chan_ctl.sv
module chan_ctl
  import chan_ctl_pkg::*;
#(
  parameter int CMD_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cono_we_i,
  input  logic [CONO_W-1:0] cono_data_i,
  input  logic              stcr_we_i,
  input  logic [CMD_W-1:0]  stcr_data_i,
  input  logic              xfer_done_i,
  input  logic [ERR_N-1:0]  err_i,
  input  logic              attn_i,
  output logic [CONI_W-1:0] coni_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic              start_o,
  output logic [CMD_W-1:0]  start_cmd_o,
  output logic              stop_o,
  output logic              list_rst_o
);
  logic ctl_rst, ctl_ld;
  logic prim_full, sec_full, drop;
  logic done, ate, ben, attn, rae;
  logic [LVL_W-1:0] lvl;
  logic [ERR_N-1:0] errs;
  logic stop_q, list_q;

  assign ctl_rst = cono_we_i & cono_data_i[C_RESET];
  assign ctl_ld  = cono_we_i & ~cono_data_i[C_RESET];

  chan_cmd_queue #(.CMD_W(CMD_W)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (ctl_rst),
    .wr_i        (stcr_we_i),
    .wr_data_i   (stcr_data_i),
    .cmpl_i      (xfer_done_i),
    .del_i       (ctl_ld & cono_data_i[C_DEL_SEC]),
    .prim_full_o (prim_full),
    .sec_full_o  (sec_full),
    .drop_o      (drop),
    .start_o     (start_o),
    .start_cmd_o (start_cmd_o)
  );

  chan_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ctl_rst),
    .ld_i       (ctl_ld),
    .lvl_i      (cono_data_i[LVL_W-1:0]),
    .ate_i      (cono_data_i[C_ATE]),
    .ben_i      (cono_data_i[C_BUS_EN]),
    .clr_done_i (ctl_ld & cono_data_i[C_CLR_DONE]),
    .clr_xfer_i (ctl_ld & cono_data_i[C_CLR_XFER]),
    .clr_rae_i  (ctl_ld & cono_data_i[C_CLR_RAE]),
    .done_set_i (xfer_done_i & prim_full & ~ctl_rst),
    .err_i      (err_i),
    .rae_set_i  (drop),
    .attn_i     (attn_i),
    .done_o     (done),
    .ate_o      (ate),
    .ben_o      (ben),
    .lvl_o      (lvl),
    .attn_o     (attn),
    .err_o      (errs),
    .rae_o      (rae),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      list_q <= 1'b0;
    end else begin
      stop_q <= ctl_ld & cono_data_i[C_STOP];
      list_q <= ctl_ld & cono_data_i[C_LIST_RST];
    end
  end

  assign stop_o     = stop_q;
  assign list_rst_o = list_q;
  assign irq_lvl_o  = lvl;

  always_comb begin
    coni_o              = '0;
    coni_o[LVL_W-1:0]   = lvl;
    coni_o[S_DONE]      = done;
    coni_o[S_PFULL]     = prim_full;
    coni_o[S_ATE]       = ate;
    coni_o[S_SFULL]     = sec_full;
    coni_o[S_ATTN]      = attn;
    coni_o[S_BUSEN]     = ben;
    coni_o[S_RAE]       = rae;
    for (int i = 0; i < ERR_N; i++) coni_o[err_pos(i)] = errs[i];
  end

  p_drop_sets_rae_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> coni_o[S_RAE]);
  p_full_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stcr_we_i && prim_full && sec_full && !xfer_done_i && !ctl_rst &&
     !(ctl_ld && cono_data_i[C_DEL_SEC])) |=> (coni_o[S_RAE] && !start_o));
  p_done_on_cmpl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && prim_full && !ctl_rst) |=> coni_o[S_DONE]);
  p_reset_queue_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst |=> (!coni_o[S_PFULL] && !coni_o[S_SFULL] && !start_o && !stop_o));
endmodule

// File: tb/chan_ctl_test.sv
module chan_ctl_test;
  localparam int CMD_W = 36;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cono_we = 1'b0;
  logic [11:0]      cono_data = '0;
  logic             stcr_we = 1'b0;
  logic [CMD_W-1:0] stcr_data = '0;
  logic             xfer_done = 1'b0;
  logic [5:0]       err = '0;
  logic             attn = 1'b0;
  logic [17:0]      coni;
  logic             irq;
  logic [2:0]       irq_lvl;
  logic             start;
  logic [CMD_W-1:0] start_cmd;
  logic             stop;
  logic             list_rst;

  int checks = 0;
  int fails = 0;
  int uid = 0;

  // reference state
  logic m_pf = 0, m_sf = 0, m_done = 0, m_rae = 0, m_ate = 0, m_ben = 0, m_attn = 0;
  logic [CMD_W-1:0] m_prim = '0, m_sec = '0;
  logic [5:0] m_err = '0;
  logic [2:0] m_lvl = '0;
  logic m_start = 0, m_stop = 0, m_lrst = 0;

  always #5 clk = ~clk;

  chan_ctl #(.CMD_W(CMD_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cono_we_i(cono_we), .cono_data_i(cono_data),
    .stcr_we_i(stcr_we), .stcr_data_i(stcr_data), .xfer_done_i(xfer_done),
    .err_i(err), .attn_i(attn), .coni_o(coni), .irq_o(irq), .irq_lvl_o(irq_lvl),
    .start_o(start), .start_cmd_o(start_cmd), .stop_o(stop), .list_rst_o(list_rst)
  );

  function automatic logic [17:0] exp_coni();
    logic [17:0] v;
    v = '0;
    v[2:0] = m_lvl;
    v[3] = m_done; v[4] = m_pf; v[5] = m_ate; v[6] = m_sf;
    v[7] = m_attn; v[8] = m_ben; v[11] = m_rae;
    v[9] = m_err[0]; v[12] = m_err[1]; v[14] = m_err[2];
    v[15] = m_err[3]; v[16] = m_err[4]; v[17] = m_err[5];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic cw, input logic [11:0] cd, input logic sw,
                     input logic [CMD_W-1:0] sd, input logic de, input logic [5:0] er,
                     input logic at, input string tag);
    logic rst, ld, dset, drop;
    @(negedge clk);
    cono_we = cw; cono_data = cd; stcr_we = sw; stcr_data = sd;
    xfer_done = de; err = er; attn = at;
    @(posedge clk);
    #1;
    rst = cw & cd[10];
    ld  = cw & ~cd[10];
    m_start = 0;
    m_stop  = ld & cd[4];
    m_lrst  = ld & cd[7];
    m_attn  = at;
    if (rst) begin
      m_pf = 0; m_sf = 0; m_done = 0; m_rae = 0; m_err = '0;
      m_ate = 0; m_ben = 0; m_lvl = '0;
    end else begin
      dset = de & m_pf;
      if (de && m_pf) begin
        if (m_sf) begin m_prim = m_sec; m_sf = 0; m_start = 1; end
        else m_pf = 0;
      end
      if (ld && cd[6]) m_sf = 0;
      drop = 0;
      if (sw) begin
        if (!m_pf) begin m_prim = sd; m_pf = 1; m_start = 1; end
        else if (!m_sf) begin m_sec = sd; m_sf = 1; end
        else drop = 1;
      end
      if (dset) m_done = 1;
      else if (ld && cd[3]) m_done = 0;
      for (int i = 0; i < 6; i++) begin
        if (er[i]) m_err[i] = 1;
        else if (ld && cd[9]) m_err[i] = 0;
      end
      if (drop) m_rae = 1;
      else if (ld && cd[11]) m_rae = 0;
      if (ld) begin m_lvl = cd[2:0]; m_ate = cd[5]; m_ben = cd[8]; end
    end
    chk({tag, " R1 status"}, 64'(coni), 64'(exp_coni()));
    chk({tag, " R11 irq"}, {60'd0, irq, irq_lvl},
        {60'd0, (m_lvl != 0) && (m_done || (m_attn && m_ate)), m_lvl});
    chk({tag, " R3 start"}, 64'(start), 64'(m_start));
    if (m_start) chk({tag, " R3 start_cmd"}, 64'(start_cmd), 64'(m_prim));
    chk({tag, " R8 pulses"}, {62'd0, stop, list_rst}, {62'd0, m_stop, m_lrst});
  endtask

  task automatic idle(input string tag);
    cyc(0, '0, 0, '0, 0, '0, m_attn, tag);
  endtask

  task automatic ctl(input logic [11:0] d, input string tag);
    cyc(1, d, 0, '0, 0, '0, m_attn, tag);
  endtask

  task automatic push(input string tag);
    uid++;
    cyc(0, '0, 1, CMD_W'(64'h8_0000_0000 + 64'(uid) * 64'h3_0041), 0, '0, m_attn, tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", 64'(coni), 64'd0);
    chk("R11 reset irq", 64'(irq), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // R2: levels and enables
    for (int v = 0; v < 32; v++)
      ctl(12'((v & 7) | (((v >> 3) & 1) << 5) | (((v >> 4) & 1) << 8)), "R2");

    // R13: attention follows the input one cycle later
    cyc(0, '0, 0, '0, 0, '0, 1, "R13");
    idle("R13");
    cyc(0, '0, 0, '0, 0, '0, 1, "R13");
    cyc(0, '0, 0, '0, 0, '0, 0, "R13");

    // R3..R7: every same-cycle combination from each queue depth
    for (int n = 0; n < 3; n++) begin
      for (int v = 0; v < 8; v++) begin
        ctl(12'h400, "R12");
        for (int k = 0; k < n; k++) push(n == 1 ? "R3" : "R4");
        uid++;
        cyc(v[2], 12'(v[2] ? 12'h040 : 12'h000), v[0],
            CMD_W'(64'h5_0000_0000 + 64'(uid)), v[1], '0, 0, "R7");
        idle("R6");
        idle("R6");
      end
    end
    // R5: drop while full, then clear RAE
    ctl(12'h400, "R12");
    push("R3"); push("R4"); push("R5"); push("R5");
    ctl(12'h200, "R9 rae kept");
    ctl(12'h800, "R9 rae clear");
    // R6: completion with empty primary is ignored
    ctl(12'h400, "R12");
    cyc(0, '0, 0, '0, 1, '0, 0, "R6 empty");
    push("R3"); push("R4");
    cyc(0, '0, 0, '0, 1, '0, 0, "R6 promote");
    idle("R6");
    cyc(0, '0, 0, '0, 1, '0, 0, "R6 last");
    idle("R6");

    // R9: error flags
    for (int i = 0; i < 6; i++) begin
      cyc(0, '0, 0, '0, 0, 6'(1 << i), 0, "R9 set");
      ctl(12'h200, "R9 clear");
      cyc(1, 12'h200, 0, '0, 0, 6'(1 << i), 0, "R9 set wins");
      ctl(12'h200, "R9 clear");
    end

    // R10: clear done, and completion beating the clear
    push("R3");
    cyc(0, '0, 0, '0, 1, '0, 0, "R10");
    ctl(12'h008, "R10 clear");
    push("R3");
    cyc(1, 12'h008, 0, '0, 1, '0, 0, "R10 set wins");

    // R11: interrupt sweep
    for (int v = 0; v < 64; v++) begin
      ctl(12'h400, "R11");
      if (v[3]) begin push("R11"); cyc(0, '0, 0, '0, 1, '0, 0, "R11"); end
      cyc(1, 12'((v & 7) | (v[4] << 5)), 0, '0, 0, '0, v[5], "R11");
      idle("R11");
    end

    // R8: stop and list-reset pulses, delete secondary
    ctl(12'h010, "R8 stop");
    idle("R8");
    ctl(12'h080, "R8 list");
    idle("R8");
    push("R8"); push("R8");
    ctl(12'h040, "R8 delete");
    idle("R8");

    // R12: reset ignores everything else in the cycle
    cyc(0, '0, 0, '0, 0, 6'h3f, 1, "R12");
    cyc(1, 12'hFFF, 1, CMD_W'(64'h7), 1, '0, 1, "R12");
    idle("R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule